// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It decodes a fixed set of nine instructions: word load and word store, five register-to-register operations (add, subtract, bitwise AND, bitwise OR, signed set-if-less), a branch taken when two registers are equal, and an absolute jump. The instruction and data stores are word arrays inside the core. Both are addressed in bytes and indexed by address bits [n+1:2], so an access covers one aligned word.

Control is decoded in two steps. A main decoder turns the 6-bit opcode into datapath enables and a 2-bit operation class. An ALU decoder turns that class, together with the function field of register-format words, into a 3-bit ALU code. The register file holds 32 words, has two combinational read ports and one write port, and register 0 is fixed at zero.

While reset is held, the surrounding logic preloads both stores through a plain word-wide load port. The core then runs from address 0. Every register writeback and every store is also driven onto observation outputs, which show the effect of the instruction being executed in the current cycle. No data stream crosses the block's edge, so the core has no valid/ready handshake and every pin is a plain level.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high the PC is 0 and no register or data write takes place. With `load_en` high during reset, `load_data` is written to word `load_addr` of the instruction store when `load_dmem` is 0, or of the data store when `load_dmem` is 1.
- R2: Each cycle out of reset executes exactly one instruction. Any instruction other than a taken branch or a jump advances the PC by 4.
- R3: Word load (opcode 35, fields op[31:26], rs[25:21], rt[20:16], imm[15:0]) writes data-store word ((rs + sign-extended imm) >> 2) into register rt. Negative offsets are allowed.
- R4: Word store (opcode 43) writes register rt to the data store at rs + sign-extended imm and writes no register. A later load from that address returns the stored word.
- R5: Register-format words (opcode 0, rd[15:11], funct[5:0]) with funct 0x20 write rs+rt to rd, and with funct 0x22 write rs−rt to rd.
- R6: Funct 0x24 writes rs AND rt to rd, and funct 0x25 writes rs OR rt to rd.
- R7: Funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise (including when they are equal).
- R8: Branch-if-equal (opcode 4) writes nothing. When rs equals rt the next PC is PC+4 plus the sign-extended imm shifted left by 2; otherwise it is PC+4.
- R9: Jump (opcode 2) writes nothing. The next PC is {PC+4 bits [31:28], field [25:0], 2'b00}.
- R10: Register 0 always reads as zero, and a write aimed at it is discarded.
- R11: Any opcode other than 0, 2, 4, 35 and 43 writes no register and no memory, and the PC advances by 4.
- R12: The main decoder gives class 00 for loads and stores, which the ALU decoder maps to code 010 (add). It gives class 01 for branches, mapped to 110 (subtract), and class 10 for register-format words, where the funct field selects 010, 110, 000 (AND), 001 (OR) or 111 (set-if-less).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe, honoured only while `rst` is high |
| load_dmem | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_addr | input | LOAD_AW (6) | Word index for the preload |
| load_data | input | 32 | Word to preload |
| pc_o | output | 32 | Address of the instruction being executed |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value being written back |
| dmem_we_o | output | 1 | Data-store write enable of the current instruction |
| dmem_addr_o | output | 32 | Byte address computed by the ALU |
| dmem_wdata_o | output | 32 | Word being stored |

## Verification
Four properties are checked on every cycle: the PC steps by exactly 4 after any word that is neither a branch nor a jump, the low 28 bits of a jump target, the read port returning zero for register 0, and the class-to-ALU-code mapping for loads, stores and branches. Also checked every cycle are the rule that a store never writes a register and the rule that an unknown opcode writes nothing. Only the directed programs can show that the arithmetic and logic results are correct and that the signed comparison resolves correctly for negative operands. The same holds for the round trip of a stored word through the data store, a negative load offset, branch targets in both directions, and the discarding of a write to register 0, which appears only when that register is read back later.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_JMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_LOAD = 6'd35;
  localparam logic [5:0] OPC_STOR = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_MEM  = 2'b00,
    CLS_BR   = 2'b01,
    CLS_REG  = 2'b10,
    CLS_NONE = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic      reg_write;
    logic      reg_dst;
    logic      alu_src;
    logic      mem_write;
    logic      mem_to_reg;
    logic      branch;
    logic      jump;
    op_class_e cls;
  } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_write: 1'b0, reg_dst: 1'b0, alu_src: 1'b0, mem_write: 1'b0,
             mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_NONE};
    case (opcode)
      OPC_REG: begin
        ctrl.reg_write = 1'b1;
        ctrl.reg_dst   = 1'b1;
        ctrl.cls       = CLS_REG;
      end
      OPC_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.cls        = CLS_MEM;
      end
      OPC_STOR: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.cls       = CLS_MEM;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_BR;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  op_class_e  cls,
  input  logic [5:0] funct,
  output alu_op_e    alu_ctl
);
  always_comb begin
    case (cls)
      CLS_MEM: alu_ctl = ALU_ADD;
      CLS_BR:  alu_ctl = ALU_SUB;
      CLS_REG: begin
        case (funct)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_ADD;
        endcase
      end
      default: alu_ctl = ALU_AND;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW     = $clog2(IMEM_WORDS),
  localparam int DAW     = $clog2(DMEM_WORDS),
  localparam int LOAD_AW = (IAW > DAW) ? IAW : DAW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               load_dmem,
  input  logic [LOAD_AW-1:0] load_addr,
  input  logic [31:0]        load_data,
  output logic [31:0]        pc_o,
  output logic               rf_we_o,
  output logic [4:0]         rf_waddr_o,
  output logic [31:0]        rf_wdata_o,
  output logic               dmem_we_o,
  output logic [31:0]        dmem_addr_o,
  output logic [31:0]        dmem_wdata_o
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [31:0] instr, imm_se, rs_data, rt_data, alu_b, alu_y, dmem_rdata, wb_data;
  logic [4:0]  wb_addr;
  logic        alu_zero;
  ctrl_t       ctrl;
  alu_op_e     alu_ctl;

  assign instr = imem[pc_q[IAW+1:2]];

  sc_main_dec u_main_dec (.opcode(instr[31:26]), .ctrl(ctrl));

  sc_alu_dec u_alu_dec (.cls(ctrl.cls), .funct(instr[5:0]), .alu_ctl(alu_ctl));

  sc_regfile #(.XLEN(32), .NREG(32)) u_rf (
    .clk     (clk),
    .ra_addr (instr[25:21]),
    .ra_data (rs_data),
    .rb_addr (instr[20:16]),
    .rb_data (rt_data),
    .we      (rf_we_o),
    .waddr   (wb_addr),
    .wdata   (wb_data)
  );

  assign imm_se = {{16{instr[15]}}, instr[15:0]};
  assign alu_b  = ctrl.alu_src ? imm_se : rt_data;

  sc_alu #(.XLEN(32)) u_alu (
    .a    (rs_data),
    .b    (alu_b),
    .op   (alu_ctl),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dmem_rdata = dmem[alu_y[DAW+1:2]];
  assign wb_addr    = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign wb_data    = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_se[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                   pc_next = jmp_target;
    else if (ctrl.branch && alu_zero) pc_next = br_target;
    else                             pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst && load_en && !load_dmem) imem[load_addr[IAW-1:0]] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (load_en && load_dmem) dmem[load_addr[DAW-1:0]] <= load_data;
    end else if (ctrl.mem_write) begin
      dmem[alu_y[DAW+1:2]] <= rt_data;
    end
  end

  assign pc_o         = pc_q;
  assign rf_we_o      = ctrl.reg_write && !rst;
  assign rf_waddr_o   = wb_addr;
  assign rf_wdata_o   = wb_data;
  assign dmem_we_o    = ctrl.mem_write && !rst;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic        rf_we,
  input logic        dmem_we,
  input logic [1:0]  cls,
  input logic [2:0]  alu_ctl,
  input logic [4:0]  rs_addr,
  input logic [31:0] rs_data
);
  logic [5:0] opc;
  logic       known;
  assign opc   = instr[31:26];
  assign known = (opc == 6'd0) || (opc == 6'd2) || (opc == 6'd4) ||
                 (opc == 6'd35) || (opc == 6'd43);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'd4 && opc != 6'd2) |=> (pc == $past(pc) + 32'd4));

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd2) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

  // R10
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_addr == 5'd0) |-> (rs_data == 32'd0));

  // R12
  mem_class_chk: assert property (@(posedge clk) disable iff (rst)
    (cls == 2'b00) |-> (alu_ctl == 3'b010));

  // R12
  br_class_chk: assert property (@(posedge clk) disable iff (rst)
    (cls == 2'b01) |-> (alu_ctl == 3'b110));

  // R4
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd43) |-> (dmem_we && !rf_we));

  // R11
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!dmem_we && !rf_we));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .instr   (instr),
  .pc      (pc_q),
  .rf_we   (rf_we_o),
  .dmem_we (dmem_we_o),
  .cls     (ctrl.cls),
  .alu_ctl (alu_ctl),
  .rs_addr (instr[25:21]),
  .rs_data (rs_data)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic        load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dmem_we_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog [32];
  logic [31:0] data [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dmem_we_o(dmem_we_o), .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  // kind: 0 = register writeback, 1 = store, 2 = no write
  task automatic step(input string req, input logic [31:0] epc, input int kind,
                      input logic [31:0] a, input logic [31:0] b);
    logic ok;
    #2;
    checks++;
    ok = (pc_o == epc);
    if (kind == 0) ok = ok && rf_we_o && !dmem_we_o && (rf_waddr_o == 5'(a)) && (rf_wdata_o == b);
    else if (kind == 1) ok = ok && dmem_we_o && !rf_we_o && (dmem_addr_o == a) && (dmem_wdata_o == b);
    else ok = ok && !dmem_we_o && !rf_we_o;
    if (!ok) begin
      errors++;
      $display("FAIL %s: pc=%h rf_we=%b wa=%0d wd=%h dwe=%b da=%h dd=%h | expected pc=%h kind=%0d a=%h b=%h",
               req, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dmem_we_o, dmem_addr_o, dmem_wdata_o,
               epc, kind, a, b);
    end
    @(negedge clk);
  endtask

  task automatic boot(input int nprog, input int ndata);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < nprog; i++) begin
      load_en = 1'b1; load_dmem = 1'b0; load_addr = 6'(i); load_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < ndata; i++) begin
      load_en = 1'b1; load_dmem = 1'b1; load_addr = 6'(i); load_data = data[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
    #2;
    checks++;
    // R1: reset holds PC at zero with no writes
    if (pc_o != 32'd0 || rf_we_o || dmem_we_o) begin
      errors++;
      $display("FAIL R1: pc=%h rf_we=%b dwe=%b expected pc=00000000 rf_we=0 dwe=0",
               pc_o, rf_we_o, dmem_we_o);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_alu_mem();
    for (int i = 0; i < 32; i++) prog[i] = 32'd0;
    prog[0]  = enc_i(6'd35, 0, 1, 16'd0);
    prog[1]  = enc_i(6'd35, 0, 2, 16'd4);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 6'h22);
    prog[4]  = enc_r(2, 1, 5, 6'h2A);
    prog[5]  = enc_r(1, 2, 6, 6'h2A);
    prog[6]  = enc_i(6'd35, 0, 7, 16'd8);
    prog[7]  = enc_i(6'd35, 0, 8, 16'd12);
    prog[8]  = enc_r(7, 8, 9, 6'h24);
    prog[9]  = enc_r(7, 8, 10, 6'h25);
    prog[10] = enc_r(1, 1, 0, 6'h20);
    prog[11] = enc_r(0, 1, 11, 6'h20);
    prog[12] = enc_i(6'd43, 0, 3, 16'd16);
    prog[13] = enc_i(6'd35, 0, 12, 16'd16);
    prog[14] = enc_i(6'd35, 0, 14, 16'd20);
    prog[15] = enc_i(6'd35, 14, 13, 16'hFFFC);
    prog[16] = 32'hFC00_0000;
    prog[17] = 32'h0C00_0000;
    prog[18] = enc_r(2, 2, 15, 6'h22);
    prog[19] = enc_r(1, 1, 16, 6'h2A);
    data[0] = 32'd5; data[1] = 32'hFFFF_FFFD; data[2] = 32'h0F0F_00FF;
    data[3] = 32'h00FF_0F0F; data[4] = 32'd0; data[5] = 32'd24;
    boot(20, 6);
    step("R3 load",          32'd0,  0, 1,  32'd5);
    step("R3 load",          32'd4,  0, 2,  32'hFFFF_FFFD);
    step("R5 add",           32'd8,  0, 3,  32'd2);
    step("R5 sub",           32'd12, 0, 4,  32'd8);
    step("R7 slt true",      32'd16, 0, 5,  32'd1);
    step("R7 slt false",     32'd20, 0, 6,  32'd0);
    step("R3 load",          32'd24, 0, 7,  32'h0F0F_00FF);
    step("R3 load",          32'd28, 0, 8,  32'h00FF_0F0F);
    step("R6 and",           32'd32, 0, 9,  32'h000F_000F);
    step("R6 or",            32'd36, 0, 10, 32'h0FFF_0FFF);
    step("R10 write r0",     32'd40, 0, 0,  32'd10);
    step("R10 r0 reads 0",   32'd44, 0, 11, 32'd5);
    step("R4 store",         32'd48, 1, 32'd16, 32'd2);
    step("R4 readback",      32'd52, 0, 12, 32'd2);
    step("R3 load base",     32'd56, 0, 14, 32'd24);
    step("R3 neg offset",    32'd60, 0, 13, 32'd24);
    step("R11 op 63",        32'd64, 2, 0, 0);
    step("R11 op 3",         32'd68, 2, 0, 0);
    step("R2 R5 sub zero",   32'd72, 0, 15, 32'd0);
    step("R7 slt equal",     32'd76, 0, 16, 32'd0);
  endtask

  task automatic test_flow();
    for (int i = 0; i < 32; i++) prog[i] = enc_r(1, 1, 20, 6'h20);
    prog[0]  = enc_i(6'd35, 0, 1, 16'd0);
    prog[1]  = enc_i(6'd35, 0, 2, 16'd4);
    prog[2]  = enc_i(6'd35, 0, 3, 16'd8);
    prog[3]  = enc_i(6'd4, 1, 3, 16'd5);
    prog[4]  = enc_i(6'd4, 1, 2, 16'd2);
    prog[7]  = enc_j(26'd10);
    prog[9]  = enc_j(26'd11);
    prog[10] = enc_i(6'd4, 0, 0, 16'd2);
    prog[11] = enc_r(1, 3, 5, 6'h20);
    prog[12] = enc_i(6'd43, 0, 5, 16'd12);
    prog[13] = enc_i(6'd4, 0, 0, 16'hFFFB);
    data[0] = 32'd7; data[1] = 32'd7; data[2] = 32'd9;
    boot(14, 3);
    step("R1 start at 0",     32'd0,  0, 1, 32'd7);
    step("R3 load",           32'd4,  0, 2, 32'd7);
    step("R3 load",           32'd8,  0, 3, 32'd9);
    step("R8 not taken",      32'd12, 2, 0, 0);
    step("R8 taken fwd",      32'd16, 2, 0, 0);
    step("R8 target R9 jump", 32'd28, 2, 0, 0);
    step("R9 target",         32'd40, 2, 0, 0);
    step("R8 taken r0",       32'd52, 2, 0, 0);
    step("R8 taken back",     32'd36, 2, 0, 0);
    step("R9 target",         32'd44, 0, 5, 32'd16);
    step("R4 store",          32'd48, 1, 32'd12, 32'd16);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_alu_mem();
    test_flow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule